// File: doc/BRIEF.md
# Dual-Channel Frame-Lining Clock-Domain Bridge

This block carries two framed 32-bit word streams into one local reference clock domain. Each stream arrives on its own recovered clock, and every word is tagged with a start-of-frame bit. Inside the block, each stream passes through its own small asynchronous FIFO. A single control machine in the reference domain decides when each FIFO is popped, so that the two streams leave with their frame-start words on the same cycle.

In alignment mode the controller first hunts. It throws away words on each channel until a frame-start word sits at that channel's head, and then holds that channel. Once both heads carry a frame start, both channels are popped together, the aligned flag rises and lock-step reading begins. The controller drops back to hunting if the two output frame pulses ever disagree, if either channel loses framing, or if alignment mode is switched off. With alignment mode off, each channel is simply drained whenever it holds data. Sticky overflow and underflow flags report a write into a full FIFO and a lock-step read of an empty one.

Top module: `frameAlignFifo`

## Requirements
- R1: Words of each channel leave the block in the order they were written, with data unchanged; channel 0 uses bits 31:0 of the data buses and channel 1 uses bits 63:32.
- R2: A write is accepted only while that channel's framed input is 1. Words offered while it is 0 never reach the output.
- R3: In alignment mode, words ahead of a channel's first frame-start word are discarded and rdValid stays 0 until lock.
- R4: At lock, the frame-start words of both channels appear on the same cycle with rdFp = 2'b11, and aligned rises on that same cycle.
- R5: While aligned, both channels present consecutive words together on every cycle.
- R6: When the output frame pulses of the two channels differ, aligned clears on that cycle and hunting restarts. The next lock pairs the next frame-start word on each channel.
- R7: When either channel's framed input drops while aligned, aligned clears within a few reference cycles.
- R8: A write into a full channel FIFO sets that channel's bit of ovfErr, and the bit stays set until reset. The FIFO holds 16 words per channel.
- R9: A lock-step read of an empty channel FIFO sets that channel's bit of udfErr, and the bit stays set until reset.
- R10: After reset all outputs are 0, and nothing is read out until both write-side resets have been released.
- R11: With alignEn = 0, each channel is drained on its own and aligned stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Local reference (read) clock |
| refRstN | input | 1 | Active-low asynchronous reset, reference domain |
| wrClk | input | 2 | Recovered write clock per channel |
| wrRstN | input | 2 | Active-low asynchronous reset per write domain |
| alignEn | input | 1 | 1 = frame alignment mode, 0 = independent drain |
| framed | input | 2 | Channel framing established |
| wrValid | input | 2 | Write strobe per channel |
| wrData | input | 64 | Write words, channel 1 in upper half |
| wrFp | input | 2 | Frame-start tag of the word being written |
| rdData | output | 64 | Read words, channel 1 in upper half |
| rdValid | output | 2 | Read word valid per channel |
| rdFp | output | 2 | Frame pulse per channel on the read side |
| aligned | output | 1 | Channels locked at frame level |
| ovfErr | output | 2 | Sticky overflow per channel |
| udfErr | output | 2 | Sticky underflow per channel |

## Verification
The hardest state to reach from the ports is a lock that breaks on a frame-pulse disagreement and then re-forms on a later pair of frame starts. To get there, the two streams carry frame markers at deliberately uneven spacings. After the first lock, the next channel-0 marker is read one word before its partner, which forces a mismatch. The bench then predicts which word indices the re-hunt must pair, given that the waiting channel banks words without overflowing its 16 entries. Both the hunt-only overflow and a delayed write-side reset release are reached by writing one channel while the other is held back.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2
  } faState_t;

  typedef struct packed {
    logic [NCH-1:0] pop;
    logic           show;
  } faStrobe_t;
endpackage

// File: rtl/fa_rst_sync.sv
module fa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  output logic rstN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rstN = chain[STAGES-1];
endmodule

// File: rtl/fa_bit_sync.sv
module fa_bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fa_chan_fifo.sv
module fa_chan_fifo #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrValid,
  input  logic          framed,
  input  logic [DW-1:0] wrData,
  input  logic          wrFp,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          pop,
  output logic          empty,
  output logic [DW-1:0] headData,
  output logic          headFp,
  output logic          ovfErr,
  output logic          udfErr
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW:0]   mem [DEPTH];
  logic [PW-1:0] wBin, wGray, wNext, rGrayW;
  logic [PW-1:0] rBin, rGray, rNext, wGrayR;
  logic          full, accept, ovfW;

  // write domain
  assign accept = wrValid & framed;
  assign wNext  = PW'(wBin + 1'b1);
  assign full   = (wGray == {~rGrayW[PW-1:PW-2], rGrayW[PW-3:0]});

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wBin  <= '0;
      wGray <= '0;
      ovfW  <= 1'b0;
    end else begin
      if (accept && !full) begin
        wBin  <= wNext;
        wGray <= wNext ^ (wNext >> 1);
      end
      if (accept && full) ovfW <= 1'b1;
    end
  end

  always_ff @(posedge wrClk) begin
    if (accept && !full) mem[wBin[AW-1:0]] <= {wrFp, wrData};
  end

  fa_bit_sync #(.W(PW)) u_rSync (.clk(wrClk), .rstN(wrRstN), .d(rGray), .q(rGrayW));

  // read domain
  fa_bit_sync #(.W(PW)) u_wSync (.clk(rdClk), .rstN(rdRstN), .d(wGray), .q(wGrayR));
  fa_bit_sync #(.W(1))  u_oSync (.clk(rdClk), .rstN(rdRstN), .d(ovfW),  .q(ovfErr));

  assign rNext    = PW'(rBin + 1'b1);
  assign empty    = (rGray == wGrayR);
  assign headData = mem[rBin[AW-1:0]][DW-1:0];
  assign headFp   = mem[rBin[AW-1:0]][DW];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rBin   <= '0;
      rGray  <= '0;
      udfErr <= 1'b0;
    end else begin
      if (pop && !empty) begin
        rBin  <= rNext;
        rGray <= rNext ^ (rNext >> 1);
      end
      if (pop && empty) udfErr <= 1'b1;
    end
  end

  AST_UNFRAMED_NO_WRITE: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !framed |=> $stable(wBin)); // R2
  AST_OVF_STICKY: assert property (@(posedge wrClk) disable iff (!wrRstN)
    ovfW |=> ovfW); // R8
  AST_UDF_STICKY: assert property (@(posedge rdClk) disable iff (!rdRstN)
    udfErr |=> udfErr); // R9
endmodule

// File: rtl/fa_datapath.sv
module fa_datapath
  import fa_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic [NCH-1:0]    wrClk,
  input  logic [NCH-1:0]    wrRstN,
  input  logic [NCH-1:0]    wrValid,
  input  logic [NCH-1:0]    framed,
  input  logic [NCH*DW-1:0] wrData,
  input  logic [NCH-1:0]    wrFp,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  faStrobe_t         strobe,
  output logic [NCH-1:0]    empty,
  output logic [NCH-1:0]    headFp,
  output logic [NCH*DW-1:0] rdData,
  output logic [NCH-1:0]    rdValid,
  output logic [NCH-1:0]    rdFp,
  output logic [NCH-1:0]    ovfErr,
  output logic [NCH-1:0]    udfErr
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] head, datQ;
    logic          take, vldQ, fpQ;

    fa_chan_fifo #(.DW(DW), .AW(AW)) u_fifo (
      .wrClk   (wrClk[ch]),
      .wrRstN  (wrRstN[ch]),
      .wrValid (wrValid[ch]),
      .framed  (framed[ch]),
      .wrData  (wrData[ch*DW +: DW]),
      .wrFp    (wrFp[ch]),
      .rdClk   (rdClk),
      .rdRstN  (rdRstN),
      .pop     (strobe.pop[ch]),
      .empty   (empty[ch]),
      .headData(head),
      .headFp  (headFp[ch]),
      .ovfErr  (ovfErr[ch]),
      .udfErr  (udfErr[ch])
    );

    assign take = strobe.pop[ch] & ~empty[ch] & strobe.show;

    always_ff @(posedge rdClk or negedge rdRstN) begin
      if (!rdRstN) begin
        vldQ <= 1'b0;
        fpQ  <= 1'b0;
        datQ <= '0;
      end else begin
        vldQ <= take;
        fpQ  <= take & headFp[ch];
        if (take) datQ <= head;
      end
    end

    assign rdValid[ch]          = vldQ;
    assign rdFp[ch]             = fpQ;
    assign rdData[ch*DW +: DW]  = datQ;
  end
endmodule

// File: rtl/fa_align_ctrl.sv
module fa_align_ctrl
  import fa_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           alignEn,
  input  logic [NCH-1:0] framedIn,
  input  logic [NCH-1:0] wrUpIn,
  input  logic [NCH-1:0] empty,
  input  logic [NCH-1:0] headFp,
  output faStrobe_t      strobe,
  output logic           aligned
);
  faState_t       st, stNext;
  logic [NCH-1:0] framedS, upS, avail, marked, fpOut;

  fa_bit_sync #(.W(NCH)) u_frSync (.clk(clk), .rstN(rstN), .d(framedIn), .q(framedS));
  fa_bit_sync #(.W(NCH)) u_upSync (.clk(clk), .rstN(rstN), .d(wrUpIn),   .q(upS));

  assign avail  = ~empty;
  assign marked = avail & headFp;
  assign fpOut  = strobe.pop & marked;

  always_comb begin
    stNext      = st;
    strobe.pop  = '0;
    strobe.show = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (&upS) stNext = ST_HUNT;
      end
      ST_HUNT: begin
        if (!alignEn) begin
          strobe.pop  = avail;
          strobe.show = 1'b1;
        end else if ((&marked) && (&framedS)) begin
          strobe.pop  = '1;
          strobe.show = 1'b1;
          stNext      = ST_LOCK;
        end else begin
          strobe.pop  = avail & ~headFp;
        end
      end
      ST_LOCK: begin
        strobe.pop  = '1;
        strobe.show = 1'b1;
        if (!alignEn || !(&framedS) || (fpOut[0] != fpOut[1])) stNext = ST_HUNT;
      end
      default: stNext = ST_IDLE;
    endcase
    if (!(&upS)) begin
      stNext      = ST_IDLE;
      strobe.pop  = '0;
      strobe.show = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assign aligned = (st == ST_LOCK);

  AST_LOCK_NEEDS_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_LOCK) |-> $past(&framedS)); // R7
  AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    !(&upS) |=> (strobe.pop == '0)); // R10
endmodule

// File: rtl/frameAlignFifo.sv
module frameAlignFifo
  import fa_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic              refClk,
  input  logic              refRstN,
  input  logic [NCH-1:0]    wrClk,
  input  logic [NCH-1:0]    wrRstN,
  input  logic              alignEn,
  input  logic [NCH-1:0]    framed,
  input  logic [NCH-1:0]    wrValid,
  input  logic [NCH*DW-1:0] wrData,
  input  logic [NCH-1:0]    wrFp,
  output logic [NCH*DW-1:0] rdData,
  output logic [NCH-1:0]    rdValid,
  output logic [NCH-1:0]    rdFp,
  output logic              aligned,
  output logic [NCH-1:0]    ovfErr,
  output logic [NCH-1:0]    udfErr
);
  logic           refRstSyncN;
  logic [NCH-1:0] wrRstSyncN, empty, headFp;
  faStrobe_t      strobe;

  fa_rst_sync u_refRst (.clk(refClk), .arstN(refRstN), .rstN(refRstSyncN));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_rst
    fa_rst_sync u_wrRst (.clk(wrClk[ch]), .arstN(wrRstN[ch]), .rstN(wrRstSyncN[ch]));
  end

  fa_datapath #(.DW(DW), .AW(AW)) u_dp (
    .wrClk  (wrClk),
    .wrRstN (wrRstSyncN),
    .wrValid(wrValid),
    .framed (framed),
    .wrData (wrData),
    .wrFp   (wrFp),
    .rdClk  (refClk),
    .rdRstN (refRstSyncN),
    .strobe (strobe),
    .empty  (empty),
    .headFp (headFp),
    .rdData (rdData),
    .rdValid(rdValid),
    .rdFp   (rdFp),
    .ovfErr (ovfErr),
    .udfErr (udfErr)
  );

  fa_align_ctrl u_ctrl (
    .clk     (refClk),
    .rstN    (refRstSyncN),
    .alignEn (alignEn),
    .framedIn(framed),
    .wrUpIn  (wrRstSyncN),
    .empty   (empty),
    .headFp  (headFp),
    .strobe  (strobe),
    .aligned (aligned)
  );

  AST_LOCK_FP_PAIRED: assert property (@(posedge refClk) disable iff (!refRstSyncN)
    $rose(aligned) |-> (rdFp == 2'b11)); // R4
  AST_BYPASS_NOT_ALIGNED: assert property (@(posedge refClk) disable iff (!refRstSyncN)
    !alignEn |=> !aligned); // R11
endmodule

// File: tb/frameAlignFifo_tb_top.sv
module frameAlignFifo_tb_top;
  logic        refClk = 1'b0;
  logic        refRstN;
  logic [1:0]  wrClkV = 2'b00;
  logic [1:0]  wrRstN;
  logic        alignEn;
  logic [1:0]  framed;
  logic        wv [2];
  logic [31:0] wd [2];
  logic        wf [2];
  logic [63:0] rdData;
  logic [1:0]  rdValid, rdFp, ovfErr, udfErr;
  logic        aligned;
  int          nChk = 0, nBad = 0;

  frameAlignFifo dut_i (
    .refClk(refClk), .refRstN(refRstN), .wrClk(wrClkV), .wrRstN(wrRstN),
    .alignEn(alignEn), .framed(framed), .wrValid({wv[1], wv[0]}),
    .wrData({wd[1], wd[0]}), .wrFp({wf[1], wf[0]}), .rdData(rdData),
    .rdValid(rdValid), .rdFp(rdFp), .aligned(aligned), .ovfErr(ovfErr), .udfErr(udfErr)
  );

  always #5 refClk = ~refClk;
  initial begin #3; forever #5 wrClkV[0] = ~wrClkV[0]; end
  initial begin #7; forever #5 wrClkV[1] = ~wrClkV[1]; end

  // jA, jB, words per channel
  localparam int VEC [5][3] = '{'{0, 0, 24}, '{3, 9, 30}, '{9, 2, 30}, '{1, 1, 20}, '{6, 6, 28}};

  function automatic logic [31:0] mkWord(input int c, input int tag, input int k);
    return {4'(c + 1), 4'h0, 8'(tag), 16'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  task automatic pushStream(input int c, input int k0, input int n, input int tag,
                            input int m0, input int m1, input int m2);
    for (int k = k0; k < k0 + n; k++) begin
      if (c == 0) @(negedge wrClkV[0]); else @(negedge wrClkV[1]);
      wv[c] = 1'b1;
      wd[c] = mkWord(c, tag, k);
      wf[c] = (k == m0) || (k == m1) || (k == m2);
    end
    if (c == 0) @(negedge wrClkV[0]); else @(negedge wrClkV[1]);
    wv[c] = 1'b0;
    wf[c] = 1'b0;
  endtask

  task automatic doReset(input bit holdB);
    wv[0] = 0; wv[1] = 0; wf[0] = 0; wf[1] = 0; wd[0] = '0; wd[1] = '0;
    framed = 2'b11;
    refRstN = 0; wrRstN = 2'b00;
    repeat (5) @(negedge refClk);
    refRstN = 1; wrRstN = {~holdB, 1'b1};
    repeat (12) @(negedge refClk);
  endtask

  task automatic waitAligned(input string req, output bit early);
    int i;
    early = 0;
    for (i = 0; i < 400 && !aligned; i++) begin
      @(negedge refClk);
      if (!aligned && rdValid != 2'b00) early = 1;
    end
    chk(aligned, req, "lock reached", 64'(aligned), 64'd1);
  endtask

  task automatic checkLock(input int tag, input int jA, input int jB, input string req);
    bit early;
    waitAligned(req, early);
    chk(!early, "R3", "no valid output before lock", 64'(early), 64'd0);
    chk(rdFp == 2'b11, "R4", "paired frame pulse at lock", 64'(rdFp), 64'd3);
    chk(rdData == {mkWord(1, tag, jB), mkWord(0, tag, jA)}, req, "marker words at lock",
        rdData, {mkWord(1, tag, jB), mkWord(0, tag, jA)});
    for (int n = 1; n <= 4; n++) begin
      @(negedge refClk);
      chk(rdValid == 2'b11 && rdData == {mkWord(1, tag, jB + n), mkWord(0, tag, jA + n)},
          "R5", "lock-step words", rdData, {mkWord(1, tag, jB + n), mkWord(0, tag, jA + n)});
    end
  endtask

  task automatic collectCh0(input int tag, input int first, input int count, input string req);
    int  got = 0;
    bit  badOrder = 0, sawAligned = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge refClk);
      if (aligned) sawAligned = 1;
      if (rdValid[0]) begin
        if (rdData[31:0] != mkWord(0, tag, first + got)) begin
          badOrder = 1;
          chk(0, req, "ch0 word order", 64'(rdData[31:0]), 64'(mkWord(0, tag, first + got)));
        end
        got++;
      end
    end
    chk(got == count, req, "ch0 word count", 64'(got), 64'(count));
    chk(!badOrder, "R1", "ch0 data in order", 64'(badOrder), 64'd0);
    chk(!sawAligned, "R11", "aligned stays low in drain mode", 64'(sawAligned), 64'd0);
  endtask

  initial begin
    #2_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit quiet;
    alignEn = 0;
    refRstN = 0; wrRstN = 2'b00; framed = 2'b11;
    wv[0] = 0; wv[1] = 0; wf[0] = 0; wf[1] = 0; wd[0] = '0; wd[1] = '0;

    // R10 reset state
    repeat (4) @(negedge refClk);
    chk(rdValid == 0 && rdFp == 0 && !aligned && ovfErr == 0 && udfErr == 0 && rdData == 0,
        "R10", "outputs zero in reset", {rdValid, rdFp, aligned, ovfErr, udfErr}, 64'd0);

    // R10: channel 1 write side held in reset, channel 0 written in drain mode
    alignEn = 0;
    doReset(1'b1);
    pushStream(0, 0, 5, 1, -1, -1, -1);
    quiet = 1;
    repeat (30) begin
      @(negedge refClk);
      if (rdValid != 0) quiet = 0;
    end
    chk(quiet, "R10", "no read while a write side is in reset", 64'(rdValid), 64'd0);
    wrRstN = 2'b11;
    collectCh0(1, 0, 5, "R10");

    // R2: unframed writes are dropped
    doReset(1'b0);
    framed = 2'b10;
    pushStream(0, 0, 6, 2, -1, -1, -1);
    framed = 2'b11;
    pushStream(0, 100, 3, 2, -1, -1, -1);
    collectCh0(2, 100, 3, "R2");

    // table of alignment scenarios
    alignEn = 1;
    for (int s = 0; s < 5; s++) begin
      doReset(1'b0);
      fork
        pushStream(0, 0, VEC[s][2], 10 + s, VEC[s][0], -1, -1);
        pushStream(1, 0, VEC[s][2], 10 + s, VEC[s][1], -1, -1);
        checkLock(10 + s, VEC[s][0], VEC[s][1], "R3");
      join
      repeat (40) @(negedge refClk);
      chk(udfErr == 2'b11, "R9", "underflow after streams end", 64'(udfErr), 64'd3);
      chk(ovfErr == 2'b00, "R8", "no overflow in balanced run", 64'(ovfErr), 64'd0);
    end

    // R8: channel 0 held at its marker while channel 1 never frames
    doReset(1'b0);
    fork
      pushStream(0, 0, 30, 20, 0, -1, -1);
      pushStream(1, 0, 30, 20, -1, -1, -1);
    join
    repeat (10) @(negedge refClk);
    chk(ovfErr == 2'b01, "R8", "overflow on stalled channel only", 64'(ovfErr), 64'd1);
    chk(!aligned && udfErr == 2'b00, "R3", "no lock without both markers",
        {aligned, udfErr}, 64'd0);
    repeat (10) @(negedge refClk);
    chk(ovfErr == 2'b01, "R8", "overflow flag sticky", 64'(ovfErr), 64'd1);

    // R7: framing loss while aligned
    doReset(1'b0);
    fork
      pushStream(0, 0, 60, 21, 2, -1, -1);
      pushStream(1, 0, 60, 21, 2, -1, -1);
      begin
        checkLock(21, 2, 2, "R7");
        framed = 2'b01;
        repeat (10) @(negedge refClk);
        chk(!aligned, "R7", "aligned clears on framing loss", 64'(aligned), 64'd0);
      end
    join
    framed = 2'b11;

    // R6: frame pulse mismatch then re-lock
    doReset(1'b0);
    fork
      pushStream(0, 0, 45, 22, 2, 8, 20);
      pushStream(1, 0, 45, 22, 4, 11, 22);
      begin
        bit seen = 0;
        checkLock(22, 2, 4, "R6");
        for (int i = 0; i < 40 && !seen; i++) begin
          @(negedge refClk);
          if (rdFp != 2'b00) seen = 1;
        end
        chk(rdFp == 2'b01, "R6", "lone frame pulse on channel 0", 64'(rdFp), 64'd1);
        chk(!aligned, "R6", "aligned clears on mismatch", 64'(aligned), 64'd0);
        checkLock(22, 20, 11, "R6");
      end
    join

    summary();
  end
endmodule